// File: doc/BRIEF.md
# Thermal Code to Temperature Converter

The block takes the raw output of an on-die thermal sensor's ADC and turns it into a junction temperature in millidegrees Celsius. It accepts sample words with a valid strobe and takes the low 12 bits of each as a code. It sums a window of eight accepted codes and averages them, then applies a curvature correction by scaled integer division. The corrected code is mapped onto a straight line fixed by two trimmed calibration codes, a hot point and a cold point. The result is rounded upward to the next half degree and presented as a signed 32-bit value, along with a one-cycle done strobe.

Each calibration word carries its own valid flag in its top bit. When the flag is clear, a built-in default code takes its place. Division is done by bit-serial sequential dividers, so one conversion takes several dozen cycles once its window has closed. While a conversion runs, incoming samples are dropped. A fresh window starts only after the done strobe.

Top module: `therm_code_conv`

## Requirements
- R1: Only bits 11:0 of a sample word form the code; bits above 11 have no effect on the result.
- R2: Exactly eight accepted samples form a window; their codes are summed and the sum is divided by eight with truncation to give the average code. Cycles with the valid strobe low are not counted.
- R3: The corrected code is avg*1000000 / (1000000 + 13*avg), truncated toward zero.
- R4: A calibration word counts as valid when its bit 31 is 1, and its code is then bits 11:0; bits 30:12 are ignored.
- R5: An invalid hot-point word is replaced by the code 3148, and an invalid cold-point word by the code 503.
- R6: The linear value is (corrected - cold) * floor(165000 / (hot - cold)) - 40000 millidegrees. The inner quotient is truncated before the multiply, and all arithmetic is signed 32-bit so that sub-zero temperatures are representable.
- R7: When hot - cold is zero or negative, the gain term is taken as 0, so the result is -40000.
- R8: The output is the smallest multiple of 500 that is greater than or equal to the linear value. This holds for negative values as well.
- R9: temp_done is high for exactly one cycle per window, and temp_mdeg keeps its value until the next done strobe.
- R10: Samples that arrive after a window's eighth sample, up to and including the cycle in which temp_done is high, are ignored. The next window starts with the first valid sample after that cycle.
- R11: A synchronous active-low reset clears the partial window, the sample count, the busy state, temp_mdeg and temp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample word is present this cycle |
| smp_word | input | 16 | Sample word; bits 11:0 are the code |
| trim_hot | input | 32 | Hot-point calibration word: bit 31 valid, bits 11:0 code |
| trim_cold | input | 32 | Cold-point calibration word: bit 31 valid, bits 11:0 code |
| temp_mdeg | output | 32 | Signed temperature in millidegrees Celsius |
| temp_done | output | 1 | One-cycle strobe when temp_mdeg is updated |

## Verification
Two events can land in the same clock edge. The first is closing a window on its eighth sample while another valid sample is already waiting. The second is the done strobe coinciding with a sample that the bench would like to count toward the next window. The bench keeps the valid strobe high with junk codes from right after the eighth sample until the done cycle, and it changes those junk codes every cycle. An extra accepted sample, or a missed one, would move the average. So each window's expected temperature, computed in the bench with 64-bit arithmetic, judges both collisions. The sweep also covers codes 0 and 4095, defaulted trims, and zero or negative calibration spans.

// File: rtl/thermcvt_pkg.sv
// Package: thermcvt_pkg
// Shared sequencing type for the thermal code converter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package thermcvt_pkg;

    // Conversion sequence: gather window, divide, multiply, round, strobe.
    typedef enum logic [2:0] {
        ST_COLLECT = 3'd0,
        ST_CURV    = 3'd1,
        ST_MAC     = 3'd2,
        ST_ROUND   = 3'd3,
        ST_FIN     = 3'd4
    } cvt_state_e;

endpackage

// File: rtl/thermcvt_acc.sv
// Module: thermcvt_acc
// Sums 2**LOG2N sample codes (low CODE_W bits of each word) and emits the
// truncated average with a one-cycle window strobe.
// Assumes en is low whenever the parent is not ready for a new sample.
module thermcvt_acc #(
    parameter int SMP_W  = 16,
    parameter int CODE_W = 12,
    parameter int LOG2N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_word,
    output logic [CODE_W-1:0] avg_code,
    output logic              win_done
);
    localparam int SUM_W = CODE_W + LOG2N;
    localparam int NSAMP = 1 << LOG2N;

    logic [SUM_W-1:0]  acc_q;
    logic [LOG2N-1:0]  cnt_q;
    logic [SUM_W-1:0]  sum_next;
    logic              take;
    logic              unused_hi;

    assign unused_hi = ^smp_word[SMP_W-1:CODE_W];
    assign take      = en && smp_valid;
    assign sum_next  = acc_q + SUM_W'(smp_word[CODE_W-1:0]);

    // Accumulate accepted codes; close the window on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            avg_code <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= 1'b0;
            if (take) begin
                if (cnt_q == LOG2N'(NSAMP - 1)) begin
                    avg_code <= sum_next[SUM_W-1:LOG2N];
                    win_done <= 1'b1;
                    acc_q    <= '0;
                    cnt_q    <= '0;
                end else begin
                    acc_q <= sum_next;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R10: nothing accepted means the partial window is untouched.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(acc_q) && $stable(cnt_q)));

    // R2: a window strobe is never followed directly by another.
    a_r2_win_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

endmodule

// File: rtl/thermcvt_div.sv
// Module: thermcvt_div
// Bit-serial restoring unsigned divider: W cycles after start, done pulses
// with quotient and remainder. Assumes start only while idle and den != 0
// (a zero divisor yields an all-ones quotient).
module thermcvt_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, quo_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q;
    logic [W:0]       shifted;
    logic             ge;
    logic [W:0]       diff;

    assign shifted = {rem_q, quo_q[W-1]};
    assign ge      = shifted >= {1'b0, den_q};
    assign diff    = shifted - {1'b0, den_q};

    // One quotient bit per cycle, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= num;
                den_q  <= den;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quo  = quo_q;
    assign rem  = rem_q;

    // R3: a finished division leaves a remainder below the divisor.
    a_r3_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && den_q != '0) |-> (rem_q < den_q));

    // R3: the sequencer never restarts a division in flight.
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

endmodule

// File: rtl/thermcvt_trim.sv
// Module: thermcvt_trim
// Selects trimmed or default hot/cold calibration codes and forms the span.
// Assumes the valid flag is the top bit of each trim word.
module thermcvt_trim #(
    parameter int TRIM_W   = 32,
    parameter int CODE_W   = 12,
    parameter int DEF_HOT  = 3148,
    parameter int DEF_COLD = 503
) (
    input  logic [TRIM_W-1:0]      trim_hot,
    input  logic [TRIM_W-1:0]      trim_cold,
    output logic [CODE_W-1:0]      cal_hot,
    output logic [CODE_W-1:0]      cal_cold,
    output logic signed [CODE_W:0] span,
    output logic                   span_pos
);
    localparam int NPT = 2;

    logic [TRIM_W-1:0] words  [NPT];
    logic [CODE_W-1:0] picked [NPT];
    logic              unused_mid;

    assign words[0]   = trim_hot;
    assign words[1]   = trim_cold;
    assign unused_mid = ^{trim_hot[TRIM_W-2:CODE_W], trim_cold[TRIM_W-2:CODE_W]};

    // Same valid-or-default selection for each calibration point.
    for (genvar g = 0; g < NPT; g++) begin : g_pick
        localparam logic [CODE_W-1:0] DEF = CODE_W'((g == 0) ? DEF_HOT : DEF_COLD);
        assign picked[g] = words[g][TRIM_W-1] ? words[g][CODE_W-1:0] : DEF;
    end

    assign cal_hot  = picked[0];
    assign cal_cold = picked[1];
    assign span     = $signed({1'b0, cal_hot}) - $signed({1'b0, cal_cold});
    assign span_pos = !span[CODE_W] && (span != '0);

endmodule

// File: rtl/therm_code_conv.sv
// Module: therm_code_conv
// Averages eight thermal ADC codes, corrects curvature, maps the result
// between two calibration points and rounds up to GRAN_MDEG millidegrees.
// Assumes OUT_W >= 32 and GAIN_W <= OUT_W so the gain divider finishes
// before the curvature divider; trim words are sampled as a window closes.
module therm_code_conv
    import thermcvt_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int CODE_W     = 12,
    parameter int TRIM_W     = 32,
    parameter int LOG2N      = 3,
    parameter int OUT_W      = 32,
    parameter int GAIN_W     = 18,
    parameter int DEF_HOT    = 3148,
    parameter int DEF_COLD   = 503,
    parameter int CORR_SCALE = 1000000,
    parameter int CORR_K     = 13,
    parameter int SPAN_MDEG  = 165000,
    parameter int BASE_MDEG  = 40000,
    parameter int GRAN_MDEG  = 500
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [SMP_W-1:0]        smp_word,
    input  logic [TRIM_W-1:0]       trim_hot,
    input  logic [TRIM_W-1:0]       trim_cold,
    output logic signed [OUT_W-1:0] temp_mdeg,
    output logic                    temp_done
);
    localparam logic [OUT_W-1:0] SCALE_W = OUT_W'(CORR_SCALE);
    localparam logic [OUT_W-1:0] K_W     = OUT_W'(CORR_K);
    localparam logic [OUT_W-1:0] GRAN_W  = OUT_W'(GRAN_MDEG);

    cvt_state_e state_q;

    // Window collection
    logic              acc_en, win_done;
    logic [CODE_W-1:0] avg_code;
    assign acc_en = (state_q == ST_COLLECT) && !win_done;

    thermcvt_acc #(.SMP_W(SMP_W), .CODE_W(CODE_W), .LOG2N(LOG2N)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(acc_en), .smp_valid(smp_valid),
        .smp_word(smp_word), .avg_code(avg_code), .win_done(win_done)
    );

    // Calibration selection
    logic [CODE_W-1:0]      cal_hot, cal_cold;
    logic signed [CODE_W:0] span;
    logic                   span_pos;

    thermcvt_trim #(.TRIM_W(TRIM_W), .CODE_W(CODE_W),
                    .DEF_HOT(DEF_HOT), .DEF_COLD(DEF_COLD)) u_trim (
        .trim_hot(trim_hot), .trim_cold(trim_cold), .cal_hot(cal_hot),
        .cal_cold(cal_cold), .span(span), .span_pos(span_pos)
    );

    logic start_cvt;
    assign start_cvt = (state_q == ST_COLLECT) && win_done;

    // Curvature correction divider
    logic [OUT_W-1:0] curv_num, curv_den, curv_quo, curv_rem;
    logic             curv_busy, curv_done;
    assign curv_num = OUT_W'(avg_code) * SCALE_W;
    assign curv_den = SCALE_W + OUT_W'(avg_code) * K_W;

    thermcvt_div #(.W(OUT_W)) u_div_curv (
        .clk(clk), .rst_n(rst_n), .start(start_cvt), .num(curv_num),
        .den(curv_den), .busy(curv_busy), .done(curv_done),
        .quo(curv_quo), .rem(curv_rem)
    );

    // Calibration gain divider, runs alongside the curvature divider
    logic [GAIN_W-1:0] gain_den, gain_quo, gain_rem;
    logic              gain_busy, gain_done;
    assign gain_den = span_pos ? GAIN_W'(span[CODE_W-1:0]) : GAIN_W'(1);

    thermcvt_div #(.W(GAIN_W)) u_div_gain (
        .clk(clk), .rst_n(rst_n), .start(start_cvt), .num(GAIN_W'(SPAN_MDEG)),
        .den(gain_den), .busy(gain_busy), .done(gain_done),
        .quo(gain_quo), .rem(gain_rem)
    );

    // Held operands between stages
    logic [CODE_W-1:0]       cal_cold_q, corr_q;
    logic                    span_pos_q;
    logic [GAIN_W-1:0]       gain_q;
    logic signed [OUT_W-1:0] x_q, temp_q;
    logic                    x_neg_q;

    // Linear map from held operands
    logic signed [CODE_W+1:0] delta;
    logic signed [OUT_W-1:0]  delta_ext, gain_ext, lin;
    logic [OUT_W-1:0]         lin_mag;
    assign delta     = $signed({2'b00, corr_q}) - $signed({2'b00, cal_cold_q});
    assign delta_ext = OUT_W'(delta);
    assign gain_ext  = $signed(OUT_W'(span_pos_q ? gain_q : '0));
    assign lin       = delta_ext * gain_ext - $signed(OUT_W'(BASE_MDEG));
    assign lin_mag   = lin[OUT_W-1] ? OUT_W'(-lin) : OUT_W'(lin);

    // Rounding divider
    logic [OUT_W-1:0] rnd_quo, rnd_rem, rnd_base;
    logic             rnd_busy, rnd_done, rnd_start;
    assign rnd_start = (state_q == ST_MAC);
    assign rnd_base  = rnd_quo * GRAN_W;

    thermcvt_div #(.W(OUT_W)) u_div_rnd (
        .clk(clk), .rst_n(rst_n), .start(rnd_start), .num(lin_mag),
        .den(GRAN_W), .busy(rnd_busy), .done(rnd_done),
        .quo(rnd_quo), .rem(rnd_rem)
    );

    logic unused_div;
    assign unused_div = ^{curv_quo[OUT_W-1:CODE_W], curv_rem, gain_rem,
                          curv_busy, rnd_busy};

    // Sequencer and operand registers for one conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_COLLECT;
            cal_cold_q <= '0;
            span_pos_q <= 1'b0;
            corr_q     <= '0;
            gain_q     <= '0;
            x_q        <= '0;
            x_neg_q    <= 1'b0;
            temp_q     <= '0;
        end else begin
            if (gain_done) gain_q <= gain_quo;
            unique case (state_q)
                ST_COLLECT: if (win_done) begin
                    cal_cold_q <= cal_cold;
                    span_pos_q <= span_pos;
                    state_q    <= ST_CURV;
                end
                ST_CURV: if (curv_done) begin
                    corr_q  <= curv_quo[CODE_W-1:0];
                    state_q <= ST_MAC;
                end
                ST_MAC: begin
                    x_q     <= lin;
                    x_neg_q <= lin[OUT_W-1];
                    state_q <= ST_ROUND;
                end
                ST_ROUND: if (rnd_done) begin
                    if (x_neg_q)
                        temp_q <= -$signed(rnd_base);
                    else if (rnd_rem != '0)
                        temp_q <= $signed(rnd_base + GRAN_W);
                    else
                        temp_q <= $signed(rnd_base);
                    state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_COLLECT;
                default: state_q <= ST_COLLECT;
            endcase
        end
    end

    assign temp_mdeg = temp_q;
    assign temp_done = (state_q == ST_FIN);

    // R9: the done strobe lasts one cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        temp_done |=> !temp_done);

    // R8: every result is a multiple of the granularity.
    a_r8_multiple: assert property (@(posedge clk) disable iff (!rst_n)
        temp_done |-> ((temp_mdeg % GRAN_MDEG) == 0));

    // R8: the result is the ceiling of the linear value.
    a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        temp_done |-> ((temp_mdeg >= x_q) && ((temp_mdeg - x_q) < GRAN_MDEG)));

    // R6: the gain quotient is ready when the corrected code arrives.
    a_r6_gain_first: assert property (@(posedge clk) disable iff (!rst_n)
        curv_done |-> !gain_busy);

    // R11: reset leaves the block collecting with a cleared result.
    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> ((state_q == ST_COLLECT) && (temp_q == '0)));

endmodule

// File: tb/sim_therm_code_conv.sv
module sim_therm_code_conv;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               smp_valid;
    logic [15:0]        smp_word;
    logic [31:0]        trim_hot, trim_cold;
    logic signed [31:0] temp_mdeg;
    logic               temp_done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    therm_code_conv u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
        .trim_hot(trim_hot), .trim_cold(trim_cold),
        .temp_mdeg(temp_mdeg), .temp_done(temp_done)
    );

    // Arithmetic model of R1..R8.
    function automatic int model(input int c[8], input logic [31:0] th, input logic [31:0] tc);
        longint sum, avg, corr, hot, cold, span, gain, x, q;
        sum = 0;
        for (int i = 0; i < 8; i++) sum += longint'(c[i] & 32'hFFF);   // R1
        avg  = sum / 8;                                                 // R2
        corr = (avg * 1000000) / (1000000 + avg * 13);                  // R3
        hot  = th[31] ? longint'(th[11:0]) : 3148;                      // R4 R5
        cold = tc[31] ? longint'(tc[11:0]) : 503;
        span = hot - cold;
        gain = (span > 0) ? (165000 / span) : 0;                        // R6 R7
        x    = (corr - cold) * gain - 40000;
        q    = x / 500;                                                 // R8
        if (x >= 0 && (x % 500) != 0) q = q + 1;
        return int'(q * 500);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Drive one window with idle gaps, then junk until done; check result and strobe.
    task automatic run_window(input int k, input int c[8], input logic [31:0] th,
                              input logic [31:0] tc, input string req);
        int exp_v;
        exp_v = model(c, th, tc);
        @(negedge clk);
        trim_hot  = th;
        trim_cold = tc;
        for (int i = 0; i < 8; i++) begin
            if (((k + i) % 3) == 0) begin
                smp_valid = 1'b0;
                smp_word  = 16'hFFFF;
                @(negedge clk);
            end
            smp_valid = 1'b1;
            smp_word  = 16'(c[i]);
            @(negedge clk);
        end
        // R10: keep valid high with changing junk until done is seen.
        for (int n = 0; !temp_done; n++) begin
            smp_valid = 1'b1;
            smp_word  = 16'((n * 2711 + k * 97) & 16'hFFFF);
            @(negedge clk);
        end
        smp_word = 16'h0FFF;   // ignored: done cycle (R10)
        check(temp_mdeg == exp_v, req, temp_mdeg, exp_v);
        @(negedge clk);
        smp_valid = 1'b0;
        check(!temp_done && temp_mdeg == exp_v, "R9 strobe/hold", temp_mdeg, exp_v);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=no_done expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c[8];
        int v, hv, lv;
        logic [31:0] th, tc;
        string req;
        rst_n = 1'b0; smp_valid = 1'b0; smp_word = '0;
        trim_hot = '0; trim_cold = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(temp_done == 1'b0, "R11 done after reset", int'(temp_done), 0);
        check(temp_mdeg == 0, "R11 value after reset", temp_mdeg, 0);
        rst_n = 1'b1;

        // R11: partial window discarded by reset.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); smp_valid = 1'b1; smp_word = 16'h0FFF;
        end
        @(negedge clk); smp_valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) c[i] = 1000 + i * 10;
        run_window(1, c, {1'b1, 19'd0, 12'd3000}, {1'b1, 19'd0, 12'd600}, "R11 R2 partial cleared");

        // Extremes: all-zero and all-max codes with upper junk (R1, R3).
        for (int i = 0; i < 8; i++) c[i] = 16'hF000;
        run_window(2, c, 32'h0, 32'h0, "R1 R3 R5 code 0");
        for (int i = 0; i < 8; i++) c[i] = 16'hAFFF;
        run_window(4, c, 32'h0, 32'h0, "R1 R3 R5 code 4095");

        // Near-exhaustive sweep of average codes, trims and spreads.
        for (int k = 0; k < 320; k++) begin
            for (int i = 0; i < 8; i++) begin
                v = (k * 13) % 4096 + (i - 3) * (k % 5) * 3;
                if (v < 0) v = 0;
                if (v > 4095) v = 4095;
                c[i] = v | (((k * 7 + i) & 15) << 12);
            end
            hv = 2900 + (k * 37) % 500;
            lv = 400 + (k * 53) % 300;
            if ((k % 41) == 7) hv = lv;
            if ((k % 41) == 8) hv = lv - 100;
            th = ((k % 4) == 1) ? {1'b0, 19'(k * 977), 12'(hv)} : {1'b1, 19'(k * 311), 12'(hv)};
            tc = ((k % 5) == 2) ? {1'b0, 19'(k * 71), 12'(lv)}  : {1'b1, 19'(k * 29), 12'(lv)};
            if (th[31] && tc[31] && hv <= lv) req = "R7 non-positive span";
            else if (!th[31] || !tc[31])      req = "R5 default trim";
            else if ((k % 2) == 0)            req = "R4 R6 trimmed map";
            else                              req = "R8 R2 rounding";
            run_window(k, c, th, tc, req);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule